// File: doc/BRIEF.md
# Glitch-Free Differential Clock Output Gate

This block gates a bank of free-running differential clock outputs from a set of asynchronous, active-low enable pins. Each pin passes through a two-flop synchronizer and a stability filter before it affects any output. Four dedicated pins each own one fixed output. Two general pins, A and B, reach their outputs through software-programmed select masks. An output that no pin controls runs unconditionally.

An output that is told to stop finishes the phase it is in and then parks with both legs low. Restarts are aligned, so every output released by the same enable change starts again on the same reference edge. The gating flops change only in the half-period where the gated leg is already low, so no output ever produces a shortened high or low phase. The block is placed between a PLL's reference clock and the output drivers. Software sets the masks, and board logic or other devices drive the pins.

Top module: `clk_out_gate`

## Requirements
- R1: Each enable pin is active low. A pin at 0 lets the outputs it controls run. A pin at 1 stops those outputs.
- R2: A pin level takes effect only after the synchronized level is the same at two consecutive rising edges of `clk_i`. A change that is seen at only one rising edge is ignored.
- R3: Bit k of `oe_fix_ni` controls exactly one output: bit 0 controls output 0, bit 1 controls output 1, bit 2 controls output 3 and bit 3 controls output 6.
- R4: Pin A (`oe_a_ni`) controls output j when bit j of `mask_a_i` is 1. Pin B (`oe_b_ni`) controls output j when bit j of `mask_b_i` is 1.
- R5: An output runs when any pin that controls it is at 0. An output that no pin controls (no fixed pin and no mask bit set) never stops.
- R6: A stopped output holds both `clk_t_o` and `clk_c_o` at 0.
- R7: No output pulse on `clk_t_o` or `clk_c_o` is shorter than half a reference period, including across stop and restart.
- R8: A stopped output restarts no earlier than 2 and no later than 6 rising edges of `clk_i` after its enable pin falls. All outputs released by the same pin change restart on the same edge.
- R9: During and just after reset, every output runs, whatever the pin levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_fix_ni | input | 4 | Dedicated enable pins, active low |
| oe_a_ni | input | 1 | General enable pin A, active low |
| oe_b_ni | input | 1 | General enable pin B, active low |
| mask_a_i | input | 8 | Outputs controlled by pin A |
| mask_b_i | input | 8 | Outputs controlled by pin B |
| clk_t_o | output | 8 | Gated true clocks |
| clk_c_o | output | 8 | Gated complement clocks |

## Verification
The case hardest to reach from the ports is a pin change that the synchronizer sees at exactly one rising edge. The stimulus raises a pin one nanosecond after an edge and drops it one nanosecond after the next edge, so only a single edge captures the pulse. The bench then confirms that the controlled output keeps toggling at every cycle of the window. Stop and restart transitions are run while pulse-width monitors watch both legs of two outputs, so a shortened phase at the moment of gating is caught.

// File: rtl/cog_pkg.sv
`timescale 1ns/1ps
package cog_pkg;
  localparam int unsigned N_OUT    = 8;
  localparam int unsigned N_FIX    = 4;
  localparam int unsigned SYNC_LEN = 2;
  localparam int unsigned N_PIN    = N_FIX + 2;
  // output index owned by each dedicated pin
  localparam int unsigned FIX_IDX [N_FIX] = '{0, 1, 3, 6};
endpackage

// File: rtl/cog_pin_filter.sv
`timescale 1ns/1ps
module cog_pin_filter #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic lvl_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic                prev_q;
  logic                lvl_q;
  logic                sync_out;

  assign sync_out = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], pin_ni};
      prev_q <= sync_out;
      if (sync_out == prev_q) lvl_q <= prev_q;
    end
  end

  assign lvl_o = lvl_q;

  // R2
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_out != prev_q) |=> $stable(lvl_q));

  // R2
  filt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> $past(sync_out == prev_q));
endmodule

// File: rtl/cog_enable_map.sv
`timescale 1ns/1ps
module cog_enable_map
  import cog_pkg::*;
(
  input  logic [N_FIX-1:0] fix_en_i,
  input  logic             a_en_i,
  input  logic             b_en_i,
  input  logic [N_OUT-1:0] mask_a_i,
  input  logic [N_OUT-1:0] mask_b_i,
  output logic [N_OUT-1:0] ctrl_o,
  output logic [N_OUT-1:0] run_o
);
  always_comb begin
    for (int unsigned j = 0; j < N_OUT; j++) begin
      logic own, own_en;
      own    = 1'b0;
      own_en = 1'b0;
      for (int unsigned k = 0; k < N_FIX; k++) begin
        if (FIX_IDX[k] == j) begin
          own    = 1'b1;
          own_en = own_en | fix_en_i[k];
        end
      end
      ctrl_o[j] = own | mask_a_i[j] | mask_b_i[j];
      run_o[j]  = ~ctrl_o[j] | own_en
                | (mask_a_i[j] & a_en_i) | (mask_b_i[j] & b_en_i);
    end
  end
endmodule

// File: rtl/cog_clk_cell.sv
`timescale 1ns/1ps
module cog_clk_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_t_o,
  output logic clk_c_o,
  output logic run_o
);
  logic en_c_q, en_t_q;

  // complement gate moves while clk is rising (complement is falling)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_c_q <= 1'b1;
    else         en_c_q <= en_i;
  end

  // true gate moves while clk is falling (true is falling)
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_t_q <= 1'b1;
    else         en_t_q <= en_c_q;
  end

  assign clk_t_o = clk_i & en_t_q;
  assign clk_c_o = ~clk_i & en_c_q;
  assign run_o   = en_c_q;

  // R7
  phase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_t_q == en_c_q);
endmodule

// File: rtl/clk_out_gate.sv
`timescale 1ns/1ps
module clk_out_gate
  import cog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FIX-1:0] oe_fix_ni,
  input  logic             oe_a_ni,
  input  logic             oe_b_ni,
  input  logic [N_OUT-1:0] mask_a_i,
  input  logic [N_OUT-1:0] mask_b_i,
  output logic [N_OUT-1:0] clk_t_o,
  output logic [N_OUT-1:0] clk_c_o
);
  logic [N_PIN-1:0] pin_n, lvl;
  logic [N_OUT-1:0] ctrl, run_next, run_q;

  assign pin_n = {oe_b_ni, oe_a_ni, oe_fix_ni};

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    cog_pin_filter #(.SYNC_LEN(SYNC_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_ni(pin_n[p]),
      .lvl_o (lvl[p])
    );
  end

  cog_enable_map u_map (
    .fix_en_i(~lvl[N_FIX-1:0]),
    .a_en_i  (~lvl[N_FIX]),
    .b_en_i  (~lvl[N_FIX+1]),
    .mask_a_i(mask_a_i),
    .mask_b_i(mask_b_i),
    .ctrl_o  (ctrl),
    .run_o   (run_next)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    cog_clk_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (run_next[j]),
      .clk_t_o(clk_t_o[j]),
      .clk_c_o(clk_c_o[j]),
      .run_o  (run_q[j])
    );

    // R5
    stop_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_q[j]) |-> $past(ctrl[j]));
  end
endmodule

// File: tb/clk_out_gate_bench.sv
`timescale 1ns/1ps
module clk_out_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fix_n = 4'hF;
  logic       a_n = 1'b1, b_n = 1'b1;
  logic [7:0] ma = 8'h00, mb = 8'h00;
  logic [7:0] t_o, c_o;

  int n_chk = 0, n_fail = 0;
  int runt_t0 = 0, runt_c0 = 0, runt_t4 = 0, runt_c4 = 0;
  realtime up_t0, up_c0, up_t4, up_c4;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_out_gate u_clk_out_gate (
    .clk_i(clk), .rst_ni(rst_n), .oe_fix_ni(fix_n), .oe_a_ni(a_n), .oe_b_ni(b_n),
    .mask_a_i(ma), .mask_b_i(mb), .clk_t_o(t_o), .clk_c_o(c_o)
  );

  // R7 pulse-width monitors
  always @(posedge t_o[0]) up_t0 = $realtime;
  always @(negedge t_o[0]) if ($realtime - up_t0 < 1.9) runt_t0++;
  always @(posedge c_o[0]) up_c0 = $realtime;
  always @(negedge c_o[0]) if ($realtime - up_c0 < 1.9) runt_c0++;
  always @(posedge t_o[4]) up_t4 = $realtime;
  always @(negedge t_o[4]) if ($realtime - up_t4 < 1.9) runt_t4++;
  always @(posedge c_o[4]) up_c4 = $realtime;
  always @(negedge c_o[4]) if ($realtime - up_c4 < 1.9) runt_c4++;

  typedef struct packed {
    logic [3:0] fix_n;
    logic       a_n;
    logic       b_n;
    logic [7:0] ma;
    logic [7:0] mb;
    logic [7:0] run;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 1'b1, 1'b1, 8'h00, 8'h00, 8'hFF},
    '{4'b1111, 1'b1, 1'b1, 8'h00, 8'h00, 8'hB4},
    '{4'b1111, 1'b0, 1'b1, 8'h81, 8'h00, 8'hB5},
    '{4'b0000, 1'b1, 1'b1, 8'h24, 8'h00, 8'hDB},
    '{4'b0101, 1'b1, 1'b1, 8'h00, 8'h02, 8'hF6},
    '{4'b1111, 1'b1, 1'b0, 8'hFF, 8'h10, 8'h10},
    '{4'b1111, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00},
    '{4'b0000, 1'b1, 1'b1, 8'h00, 8'h00, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // running = toggling on both legs; stopped = both legs low in both phases
  task automatic sample_run(output logic [7:0] run, output bit ok);
    logic [7:0] th, ch, tl, cl;
    @(posedge clk); #1; th = t_o; ch = c_o;
    @(negedge clk); #1; tl = t_o; cl = c_o;
    run = th;
    ok  = (ch == 8'h00) && (tl == 8'h00) && (cl == th);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] run;
    bit ok;
    wait_cyc(3);
    #1 rst_n = 1'b1;
    // R9: pins all high, outputs still run right after reset
    sample_run(run, ok);
    chk(ok && run == 8'hFF, "R9", "run after reset", {24'h0, run}, 32'hFF);

    // R1 R3 R4 R5 R6 vector walk
    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #1;
      fix_n = VECS[v].fix_n; a_n = VECS[v].a_n; b_n = VECS[v].b_n;
      ma = VECS[v].ma; mb = VECS[v].mb;
      wait_cyc(12);
      sample_run(run, ok);
      chk(ok && run == VECS[v].run, "R1/R3/R4/R5/R6", $sformatf("vector %0d", v),
          {24'h0, run}, {24'h0, VECS[v].run});
    end

    // R2: high pulse on fixed pin 0 seen at a single rising edge is ignored
    begin
      bit held = 1'b1;
      @(posedge clk); #1 fix_n[0] = 1'b1;
      @(posedge clk); #1 fix_n[0] = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(posedge clk); #1;
        if (t_o[0] !== 1'b1) held = 1'b0;
      end
      chk(held, "R2", "one-edge pulse ignored", {31'h0, held}, 32'h1);
    end

    // R8: restart latency and alignment of outputs 0,1,3,6
    @(posedge clk); #1 fix_n = 4'hF;
    wait_cyc(12);
    @(posedge clk); #1 fix_n = 4'h0;
    begin
      int first = 0;
      logic [7:0] seen = 8'h00;
      for (int k = 1; k <= 10; k++) begin
        @(posedge clk); #1;
        if (first == 0 && (t_o & 8'h4B) != 8'h00) begin
          first = k;
          seen  = t_o & 8'h4B;
        end
      end
      chk(first >= 2 && first <= 6, "R8", "restart edge count", first, 6);
      chk(seen == 8'h4B, "R8", "aligned restart", {24'h0, seen}, 32'h4B);
    end

    // R2 R1: a stable high on pin A with mask selecting output 4 stops it
    @(posedge clk); #1 ma = 8'h10; a_n = 1'b1;
    wait_cyc(12);
    sample_run(run, ok);
    chk(ok && run == 8'hEF, "R1", "pin A stop", {24'h0, run}, 32'hEF);

    // R7: no shortened phase across all the stops and restarts above
    chk(runt_t0 + runt_c0 + runt_t4 + runt_c4 == 0, "R7", "runt pulses",
        runt_t0 + runt_c0 + runt_t4 + runt_c4, 0);

    finish_run();
  end
endmodule